// File: doc/BRIEF.md
# Tone Steering and Output Latch

This block sits behind a dual-tone decoder. From the decoder it takes a raw detect flag and a 4-bit key code. It decides when a tone is a real digit and when a gap is a real pause between digits. Two stages of digital timers do this work, in place of an external RC network. The first stage is a fast early-steering signal. It follows the qualified detect flag once the flag has held steady for a short debounce count. The second stage is a pair of guard timers running on the early-steering signal. One guard sets the data-valid output after a tone has lasted long enough. The other clears it after a pause has lasted long enough.

When the present guard expires, the key code is captured into an output register. Data-valid rises one clock later, so the code is already on the bus when the strobe appears. After data-valid falls, the register keeps the code until the next digit is accepted. An active-high output enable drives the register onto a tri-state bus. An inhibit input can block the four letter keys. A power-down input freezes all timing state.

All timers count ticks of a prescaled enable, one tick every `TICK_DIV` system clocks. With a 1 kHz tick, the counts are in milliseconds.

Top module: `tone_steer`

## Requirements
- R1: After reset, `early_steer` and `data_valid` are 0 and the output register holds 4'h0.
- R2: `early_steer` rises once the qualified detect has stayed high for `EST_ON` consecutive ticks. It falls once the qualified detect has stayed low for `EST_OFF` consecutive ticks. Any earlier return to the current level restarts the count.
- R3: With EST_ON=16, EST_OFF=8, GUARD_ON=26 and GUARD_OFF=34, a tone of 42 ticks or more produces exactly one `data_valid` pulse, and a tone of 20 ticks or less produces none.
- R4: With the same counts, a dropout of 20 ticks or less inside a tone leaves `data_valid` high throughout. A pause of 42 ticks or more between two tones produces two separate pulses.
- R5: The key code is captured on the clock where the present guard expires, and `data_valid` rises on the following clock. The bus already shows the new code on the last clock before the rise.
- R6: After `data_valid` falls, the bus keeps the last captured code until the next accepted digit. A code change while `data_valid` is high, with no accepted pause in between, is not captured.
- R7: When `out_en` is 0, all four `data_bus` lines are high impedance. When `out_en` is 1, they drive the captured code.
- R8: While `inhibit` is 1, a detect carrying code 4'hD, 4'hE, 4'hF or 4'h0 (the four letter keys) counts as no tone. With `inhibit` at 0, these codes are accepted like any other.
- R9: While `power_down` is 1, the prescaler, all counters, `early_steer`, `data_valid` and the output register hold their values, whatever the detect input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_detect | input | 1 | Tone-pair present flag from the decoder |
| raw_code | input | 4 | Key code from the decoder |
| inhibit | input | 1 | Blocks the four letter codes when high |
| power_down | input | 1 | Freezes all state when high |
| out_en | input | 1 | Drives the data bus when high, high impedance when low |
| early_steer | output | 1 | Debounced tone-present signal |
| data_valid | output | 1 | Accepted-digit strobe |
| data_bus | output | 4 | Captured key code, tri-state |

## Verification
An early-steering counter holding a wrong value shows up as an edge of `early_steer` that comes a tick too early or too late. It therefore appears within `EST_ON` or `EST_OFF` ticks of the detect edge. A wrong guard state shows up in two ways: an extra or missing `data_valid` pulse, or a pulse that fails to survive a short dropout. Both show within one guard window, at most `GUARD_OFF` ticks. A capture taken on the wrong clock shows at the `data_valid` rise itself. At that point the bus differs from the code the decoder presented, or changes on the rising clock.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

  // Letter keys: codes 13, 14, 15 and 0
  function automatic logic is_letter(input logic [3:0] code);
    return (code == 4'h0) || (code >= 4'hD);
  endfunction

  // Detect after the letter-key block is applied
  function automatic logic qualify(input logic det, input logic [3:0] code,
                                   input logic inh);
    return det && !(inh && is_letter(code));
  endfunction

  // Counter width able to hold values up to n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = !hold;
    end else begin : g_div
      localparam int unsigned W = tone_steer_pkg::cnt_width(DIV - 1);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (!hold) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
      assign tick = !hold && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/steer_stage.sv
module steer_stage #(
  parameter int unsigned RISE_N = 16,
  parameter int unsigned FALL_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  input  logic din,
  output logic state,
  output logic flip
);
  localparam int unsigned MAXN = (RISE_N > FALL_N) ? RISE_N : FALL_N;
  localparam int unsigned W = tone_steer_pkg::cnt_width(MAXN);
  localparam logic [W-1:0] RLIM = W'(RISE_N);
  localparam logic [W-1:0] FLIM = W'(FALL_N);

  logic [W-1:0] cnt;
  logic [W-1:0] lim;
  logic         differ;

  assign lim    = state ? FLIM : RLIM;
  assign differ = (din != state);
  assign flip   = !hold && differ && tick && (cnt + 1'b1 == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      state <= 1'b0;
    end else if (!hold) begin
      if (!differ)   cnt <= '0;
      else if (flip) begin
        cnt   <= '0;
        state <= ~state;
      end else if (tick) cnt <= cnt + 1'b1;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < lim);

  // R2
  flip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |-> $past(tick));
endmodule

// File: rtl/out_latch.sv
module out_latch #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] code_in,
  input  logic          out_en,
  output logic [DW-1:0] held,
  output logic [DW-1:0] data_bus
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= code_in;
  end

  assign data_bus = out_en ? held : {DW{1'bz}};
endmodule

// File: rtl/tone_steer.sv
module tone_steer #(
  parameter int unsigned TICK_DIV  = 100000,
  parameter int unsigned EST_ON    = 16,
  parameter int unsigned EST_OFF   = 8,
  parameter int unsigned GUARD_ON  = 26,
  parameter int unsigned GUARD_OFF = 34
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_detect,
  input  logic [3:0] raw_code,
  input  logic       inhibit,
  input  logic       power_down,
  input  logic       out_en,
  output logic       early_steer,
  output logic       data_valid,
  output logic [3:0] data_bus
);
  import tone_steer_pkg::*;

  logic       tick;
  logic       qual;
  logic       est_flip;
  logic       guard_state;
  logic       guard_flip;
  logic       capture;
  logic [3:0] held;

  assign qual = qualify(raw_detect, raw_code, inhibit);

  tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .hold(power_down), .tick(tick)
  );

  steer_stage #(.RISE_N(EST_ON), .FALL_N(EST_OFF)) u_est (
    .clk(clk), .rst_n(rst_n), .hold(power_down), .tick(tick),
    .din(qual), .state(early_steer), .flip(est_flip)
  );

  steer_stage #(.RISE_N(GUARD_ON), .FALL_N(GUARD_OFF)) u_guard (
    .clk(clk), .rst_n(rst_n), .hold(power_down), .tick(tick),
    .din(early_steer), .state(guard_state), .flip(guard_flip)
  );

  // Capture on the present-guard expiry only
  assign capture = guard_flip && !guard_state;

  out_latch #(.DW(4)) u_latch (
    .clk(clk), .rst_n(rst_n), .capture(capture), .code_in(raw_code),
    .out_en(out_en), .held(held), .data_bus(data_bus)
  );

  // data_valid trails the guard by one clock, giving the bus setup time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           data_valid <= 1'b0;
    else if (!power_down) data_valid <= guard_state;
  end

  // R5
  setup_before_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $stable(held) && $past(early_steer));

  // R6
  hold_after_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $past(data_valid)) |-> $stable(held));

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> $stable(early_steer) && $stable(data_valid) && $stable(held));

  // R3
  est_gates_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard_state) |-> $past(early_steer));
endmodule

// File: tb/tone_steer_test.sv
module tone_steer_test;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw_detect = 1'b0;
  logic [3:0] raw_code = 4'h0;
  logic       inhibit = 1'b0;
  logic       power_down = 1'b0;
  logic       out_en = 1'b1;
  logic       early_steer;
  logic       data_valid;
  logic [3:0] data_bus;

  int n_chk = 0;
  int n_bad = 0;
  int rises = 0;
  int falls = 0;
  int order_bad = 0;
  logic [3:0] rise_code = 4'h0;
  logic       prev_dv = 1'b0;
  logic [3:0] prev_bus = 4'h0;

  always #5 clk = ~clk;

  tone_steer #(.TICK_DIV(DIV), .EST_ON(16), .EST_OFF(8),
               .GUARD_ON(26), .GUARD_OFF(34)) uut (
    .clk(clk), .rst_n(rst_n), .raw_detect(raw_detect), .raw_code(raw_code),
    .inhibit(inhibit), .power_down(power_down), .out_en(out_en),
    .early_steer(early_steer), .data_valid(data_valid), .data_bus(data_bus)
  );

  // Edge monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (data_valid && !prev_dv) begin
        rises++;
        rise_code = data_bus;
        if (prev_bus !== data_bus) order_bad++;
      end
      if (!data_valid && prev_dv) falls++;
    end
    prev_dv  = data_valid;
    prev_bus = data_bus;
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * DIV) @(posedge clk);
    #1;
  endtask

  task automatic tone(input logic [3:0] code, input int on_t, input int off_t);
    raw_code = code; raw_detect = 1'b1;
    ticks(on_t);
    raw_detect = 1'b0;
    ticks(off_t);
  endtask

  task automatic t_reset;
    check("R1 early_steer", early_steer, 0);
    check("R1 data_valid", data_valid, 0);
    check("R1 bus", data_bus, 4'h0);
  endtask

  task automatic t_long_tone;
    int r0 = rises;
    raw_code = 4'h5; raw_detect = 1'b1;
    ticks(10);
    check("R2 est low before delay", early_steer, 0);
    ticks(15);
    check("R2 est high after delay", early_steer, 1);
    ticks(20);
    raw_detect = 1'b0;
    ticks(15);
    check("R2 est low after release", early_steer, 0);
    ticks(85);
    check("R3 one pulse for long tone", rises - r0, 1);
    check("R5 code at dv rise", rise_code, 4'h5);
    check("R6 dv low after pause", data_valid, 0);
    check("R6 code held", data_bus, 4'h5);
  endtask

  task automatic t_short_tone;
    int r0 = rises;
    tone(4'h9, 20, 60);
    check("R3 short tone rejected", rises - r0, 0);
    check("R6 bus unchanged", data_bus, 4'h5);
  endtask

  task automatic t_dropout;
    int r0 = rises;
    int f0 = falls;
    tone(4'h9, 50, 15);
    check("R4 dv high across dropout", data_valid, 1);
    tone(4'h3, 50, 120);
    check("R4 single pulse", rises - r0, 1);
    check("R4 single fall", falls - f0, 1);
    check("R6 no new digit", data_bus, 4'h9);
  endtask

  task automatic t_two_digits;
    int r0 = rises;
    tone(4'h2, 50, 60);
    check("R4 first digit", rise_code, 4'h2);
    tone(4'h8, 50, 120);
    check("R4 two pulses", rises - r0, 2);
    check("R5 second code", rise_code, 4'h8);
  endtask

  task automatic t_inhibit;
    int r0 = rises;
    inhibit = 1'b1;
    raw_code = 4'hD; raw_detect = 1'b1;
    ticks(30);
    check("R8 letter blocked est", early_steer, 0);
    ticks(20);
    raw_detect = 1'b0;
    ticks(60);
    check("R8 letter blocked dv", rises - r0, 0);
    tone(4'h4, 50, 120);
    check("R8 digit passes", rise_code, 4'h4);
    inhibit = 1'b0;
    tone(4'h0, 50, 120);
    check("R8 letter accepted uninhibited", rise_code, 4'h0);
    tone(4'hE, 50, 120);
    check("R8 code E captured", data_bus, 4'hE);
  endtask

  task automatic t_out_en;
    out_en = 1'b0;
    #2;
    n_chk++;
    if (!((data_bus === 4'bzzzz) || (data_bus === 4'b0000))) begin
      n_bad++;
      $display("FAIL R7 bus not released: actual %0h expected z", data_bus);
    end
    out_en = 1'b1;
    #2;
    check("R7 bus driven", data_bus, 4'hE);
  endtask

  task automatic t_power_down;
    int r0 = rises;
    raw_code = 4'h7; raw_detect = 1'b1;
    ticks(30);
    check("R9 est high before freeze", early_steer, 1);
    power_down = 1'b1;
    raw_detect = 1'b0;
    ticks(100);
    check("R9 est frozen", early_steer, 1);
    check("R9 dv frozen", data_valid, 0);
    power_down = 1'b0;
    ticks(80);
    check("R9 no digit after freeze", rises - r0, 0);
    check("R9 est released", early_steer, 0);
  endtask

  initial begin
    #1;
    t_reset;
    #20 rst_n = 1'b1;
    ticks(3);
    t_reset;
    t_long_tone;
    t_short_tone;
    t_dropout;
    t_two_digits;
    t_inhibit;
    t_out_en;
    t_power_down;
    check("R5 bus stable at dv rise", order_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule